// File: doc/BRIEF.md
# Host Bridge Load/Store Address Router

This block sits on the system side of a host bridge and classifies every processor load or store address. An address may belong to a system control area, to one of several system memory spaces, to one of up to two peripheral memory windows, or to the bridge's single peripheral I/O window. An address that belongs to none of these is undefined space. For each address the block returns a route code, the index of the matching window, the address to forward, and an invalid-address flag.

Addresses bound for the peripheral I/O window are rebased so that the window starts at zero on the I/O bus. A peripheral memory window that lies at or above 4 GB can be relocated onto a configured base below 4 GB, so that adapters with only 32-bit addressing can reach it. A window below 4 GB always passes addresses through unchanged. Window bounds, relocation bases and enables are written through a simple configuration write port. The decode is registered, so every request produces exactly one response one cycle later and the block never stalls.

Top module: `hbr_addr_router`

## Requirements
- R1: Each cycle with `req_valid` high gives `rsp_valid` high on the next cycle, with no stall for any address. A cycle with `req_valid` low gives `rsp_valid` low on the next cycle.
- R2: Route codes on `rsp_route` are 0 undefined, 1 control area, 2 peripheral I/O, 3 peripheral memory and 4 system memory. When several windows match, the control area wins, then peripheral I/O, then peripheral memory, then system memory. Within one kind the lowest index wins, and `rsp_idx` reports that index.
- R3: An address with bottom <= addr <= top of an enabled control area routes with code 1 and is forwarded unchanged. Both bounds are inclusive.
- R4: An address inside the enabled peripheral I/O window is forwarded as addr minus the window bottom.
- R5: A peripheral memory window whose bottom is below 0x1_0000_0000 forwards addresses unchanged, even when its relocate bit is set.
- R6: A peripheral memory window whose bottom is at or above 0x1_0000_0000 forwards addr - bottom + relocation base when its relocate bit is set, and forwards addr unchanged when the bit is clear.
- R7: A system memory address is forwarded unchanged. The bottom of space 0 is fixed at 0, and writes to it have no effect. The bottom of any other space has address bits 11:0 forced to zero when written.
- R8: An address that matches no enabled window gives route 0 and `rsp_err` = 1, with the address forwarded unchanged. `rsp_err` is 0 on every other response and whenever `rsp_valid` is 0.
- R9: A window whose enable bit is 0 never matches.
- R10: After reset, `rsp_valid` and `rsp_err` are 0 and every window is disabled, with its bounds reset to 0.
- R11: A configuration write takes effect on the cycle after `cfg_we` and selects its register with `cfg_kind` and `cfg_idx`. The kind codes are: 0 control bottom, 1 control top, 2 I/O bottom, 3 I/O top, 4 memory-window bottom, 5 memory-window top, 6 memory-window relocation base, 7 system-memory bottom, 8 system-memory top, 9 control enable, 10 I/O enable, 11 memory-window enable, 12 system-memory enable. For an enable write, `cfg_wdata` bit 0 is the enable and bit 1 is the relocate bit (memory windows only). An index beyond the instances of a kind is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 4 | Register kind being written |
| cfg_idx | input | 3 | Instance index within the kind |
| cfg_wdata | input | ADDR_W | Configuration write data |
| req_valid | input | 1 | Address valid |
| req_addr | input | ADDR_W | System-side load/store address |
| rsp_valid | output | 1 | Decode result valid |
| rsp_route | output | 3 | Route code |
| rsp_idx | output | 3 | Index of the matching window |
| rsp_addr | output | ADDR_W | Forwarded (possibly translated) address |
| rsp_err | output | 1 | Invalid-address flag |

## Verification
The bench builds the router with its defaults: a 48-bit address, two control areas, two peripheral memory windows and four system memory spaces. This puts both memory-window slots within reach, so one can sit below 4 GB with its relocate bit set but ignored while the other sits above 4 GB and is relocated. The four memory spaces allow a space that overlaps a peripheral memory window to exercise priority. Addresses above 4 GB reach up to the 256 TB limit, where random stimulus lands mostly in undefined space.

// File: rtl/hbr_pkg.sv
package hbr_pkg;

  typedef enum logic [2:0] {
    RT_UNDEF = 3'd0,
    RT_CTL   = 3'd1,
    RT_PIO   = 3'd2,
    RT_PMEM  = 3'd3,
    RT_SMEM  = 3'd4
  } route_e;

  localparam int KIND_W = 4;
  localparam int IDX_W  = 3;

  localparam logic [KIND_W-1:0] K_CTL_BOT = 4'd0;
  localparam logic [KIND_W-1:0] K_CTL_TOP = 4'd1;
  localparam logic [KIND_W-1:0] K_PIO_BOT = 4'd2;
  localparam logic [KIND_W-1:0] K_PIO_TOP = 4'd3;
  localparam logic [KIND_W-1:0] K_PM_BOT  = 4'd4;
  localparam logic [KIND_W-1:0] K_PM_TOP  = 4'd5;
  localparam logic [KIND_W-1:0] K_PM_IOB  = 4'd6;
  localparam logic [KIND_W-1:0] K_SM_BOT  = 4'd7;
  localparam logic [KIND_W-1:0] K_SM_TOP  = 4'd8;
  localparam logic [KIND_W-1:0] K_CTL_EN  = 4'd9;
  localparam logic [KIND_W-1:0] K_PIO_EN  = 4'd10;
  localparam logic [KIND_W-1:0] K_PM_EN   = 4'd11;
  localparam logic [KIND_W-1:0] K_SM_EN   = 4'd12;

endpackage

// File: rtl/hbr_cfg_regs.sv
module hbr_cfg_regs
  import hbr_pkg::*;
#(
  parameter int ADDR_W  = 48,
  parameter int NUM_CTL = 2,
  parameter int NUM_PIO = 1,
  parameter int NUM_PM  = 2,
  parameter int NUM_SM  = 4
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              cfg_we,
  input  logic [KIND_W-1:0]                 cfg_kind,
  input  logic [IDX_W-1:0]                  cfg_idx,
  input  logic [ADDR_W-1:0]                 cfg_wdata,
  output logic [NUM_CTL-1:0][ADDR_W-1:0]    ctl_bot,
  output logic [NUM_CTL-1:0][ADDR_W-1:0]    ctl_top,
  output logic [NUM_CTL-1:0]                ctl_en,
  output logic [NUM_PIO-1:0][ADDR_W-1:0]    pio_bot,
  output logic [NUM_PIO-1:0][ADDR_W-1:0]    pio_top,
  output logic [NUM_PIO-1:0]                pio_en,
  output logic [NUM_PM-1:0][ADDR_W-1:0]     pm_bot,
  output logic [NUM_PM-1:0][ADDR_W-1:0]     pm_top,
  output logic [NUM_PM-1:0][ADDR_W-1:0]     pm_iob,
  output logic [NUM_PM-1:0]                 pm_en,
  output logic [NUM_PM-1:0]                 pm_rel,
  output logic [NUM_SM-1:0][ADDR_W-1:0]     sm_bot,
  output logic [NUM_SM-1:0][ADDR_W-1:0]     sm_top,
  output logic [NUM_SM-1:0]                 sm_en
);

  localparam int PAGE_BITS = 12;

  // control areas
  for (genvar g = 0; g < NUM_CTL; g++) begin : g_ctl
    wire hit = cfg_we && (cfg_idx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (rst) begin
        ctl_bot[g] <= '0;
        ctl_top[g] <= '0;
        ctl_en[g]  <= 1'b0;
      end else if (hit) begin
        case (cfg_kind)
          K_CTL_BOT: ctl_bot[g] <= cfg_wdata;
          K_CTL_TOP: ctl_top[g] <= cfg_wdata;
          K_CTL_EN:  ctl_en[g]  <= cfg_wdata[0];
          default: ;
        endcase
      end
    end
  end

  // peripheral I/O windows
  for (genvar g = 0; g < NUM_PIO; g++) begin : g_pio
    wire hit = cfg_we && (cfg_idx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (rst) begin
        pio_bot[g] <= '0;
        pio_top[g] <= '0;
        pio_en[g]  <= 1'b0;
      end else if (hit) begin
        case (cfg_kind)
          K_PIO_BOT: pio_bot[g] <= cfg_wdata;
          K_PIO_TOP: pio_top[g] <= cfg_wdata;
          K_PIO_EN:  pio_en[g]  <= cfg_wdata[0];
          default: ;
        endcase
      end
    end
  end

  // peripheral memory windows
  for (genvar g = 0; g < NUM_PM; g++) begin : g_pm
    wire hit = cfg_we && (cfg_idx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (rst) begin
        pm_bot[g] <= '0;
        pm_top[g] <= '0;
        pm_iob[g] <= '0;
        pm_en[g]  <= 1'b0;
        pm_rel[g] <= 1'b0;
      end else if (hit) begin
        case (cfg_kind)
          K_PM_BOT: pm_bot[g] <= cfg_wdata;
          K_PM_TOP: pm_top[g] <= cfg_wdata;
          K_PM_IOB: pm_iob[g] <= cfg_wdata;
          K_PM_EN: begin
            pm_en[g]  <= cfg_wdata[0];
            pm_rel[g] <= cfg_wdata[1];
          end
          default: ;
        endcase
      end
    end
  end

  // system memory spaces; space 0 is anchored at address zero
  for (genvar g = 0; g < NUM_SM; g++) begin : g_sm
    wire hit = cfg_we && (cfg_idx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (rst) begin
        sm_top[g] <= '0;
        sm_en[g]  <= 1'b0;
      end else if (hit) begin
        case (cfg_kind)
          K_SM_TOP: sm_top[g] <= cfg_wdata;
          K_SM_EN:  sm_en[g]  <= cfg_wdata[0];
          default: ;
        endcase
      end
    end
    if (g == 0) begin : g_anchor
      assign sm_bot[g] = '0;
    end else begin : g_free
      always_ff @(posedge clk) begin
        if (rst)
          sm_bot[g] <= '0;
        else if (hit && cfg_kind == K_SM_BOT)
          sm_bot[g] <= {cfg_wdata[ADDR_W-1:PAGE_BITS], {PAGE_BITS{1'b0}}};
      end
    end
  end

endmodule

// File: rtl/hbr_range_hit.sv
module hbr_range_hit #(
  parameter int ADDR_W = 48,
  parameter int N      = 2
) (
  input  logic [ADDR_W-1:0]          addr,
  input  logic [N-1:0][ADDR_W-1:0]   bot,
  input  logic [N-1:0][ADDR_W-1:0]   top,
  input  logic [N-1:0]               en,
  output logic [N-1:0]               hit
);

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit[g] = en[g] && (addr >= bot[g]) && (addr <= top[g]);
  end

endmodule

// File: rtl/hbr_first_hit.sv
module hbr_first_hit #(
  parameter int N  = 4,
  parameter int IW = 3
) (
  input  logic [N-1:0]  hit,
  output logic          any,
  output logic [IW-1:0] idx
);

  always_comb begin
    any = |hit;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit[i]) idx = IW'(i);
    end
  end

endmodule

// File: rtl/hbr_addr_router.sv
module hbr_addr_router
  import hbr_pkg::*;
#(
  parameter int ADDR_W  = 48,
  parameter int NUM_CTL = 2,
  parameter int NUM_PM  = 2,
  parameter int NUM_SM  = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_we,
  input  logic [3:0]           cfg_kind,
  input  logic [2:0]           cfg_idx,
  input  logic [ADDR_W-1:0]    cfg_wdata,
  input  logic                 req_valid,
  input  logic [ADDR_W-1:0]    req_addr,
  output logic                 rsp_valid,
  output logic [2:0]           rsp_route,
  output logic [2:0]           rsp_idx,
  output logic [ADDR_W-1:0]    rsp_addr,
  output logic                 rsp_err
);

  localparam int NUM_PIO = 1;
  localparam logic [ADDR_W-1:0] FOUR_G = ADDR_W'(64'h1_0000_0000);

  logic [NUM_CTL-1:0][ADDR_W-1:0] ctl_bot, ctl_top;
  logic [NUM_CTL-1:0]             ctl_en;
  logic [NUM_PIO-1:0][ADDR_W-1:0] pio_bot, pio_top;
  logic [NUM_PIO-1:0]             pio_en;
  logic [NUM_PM-1:0][ADDR_W-1:0]  pm_bot, pm_top, pm_iob;
  logic [NUM_PM-1:0]              pm_en, pm_rel;
  logic [NUM_SM-1:0][ADDR_W-1:0]  sm_bot, sm_top;
  logic [NUM_SM-1:0]              sm_en;

  hbr_cfg_regs #(
    .ADDR_W(ADDR_W), .NUM_CTL(NUM_CTL), .NUM_PIO(NUM_PIO),
    .NUM_PM(NUM_PM), .NUM_SM(NUM_SM)
  ) u_cfg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
    .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .ctl_bot(ctl_bot), .ctl_top(ctl_top), .ctl_en(ctl_en),
    .pio_bot(pio_bot), .pio_top(pio_top), .pio_en(pio_en),
    .pm_bot(pm_bot), .pm_top(pm_top), .pm_iob(pm_iob),
    .pm_en(pm_en), .pm_rel(pm_rel),
    .sm_bot(sm_bot), .sm_top(sm_top), .sm_en(sm_en)
  );

  logic [NUM_CTL-1:0] ctl_hit;
  logic [NUM_PIO-1:0] pio_hit;
  logic [NUM_PM-1:0]  pm_hit;
  logic [NUM_SM-1:0]  sm_hit;

  hbr_range_hit #(.ADDR_W(ADDR_W), .N(NUM_CTL)) u_ctl_hit (
    .addr(req_addr), .bot(ctl_bot), .top(ctl_top), .en(ctl_en), .hit(ctl_hit));
  hbr_range_hit #(.ADDR_W(ADDR_W), .N(NUM_PIO)) u_pio_hit (
    .addr(req_addr), .bot(pio_bot), .top(pio_top), .en(pio_en), .hit(pio_hit));
  hbr_range_hit #(.ADDR_W(ADDR_W), .N(NUM_PM)) u_pm_hit (
    .addr(req_addr), .bot(pm_bot), .top(pm_top), .en(pm_en), .hit(pm_hit));
  hbr_range_hit #(.ADDR_W(ADDR_W), .N(NUM_SM)) u_sm_hit (
    .addr(req_addr), .bot(sm_bot), .top(sm_top), .en(sm_en), .hit(sm_hit));

  logic             ctl_any, pio_any, pm_any, sm_any;
  logic [IDX_W-1:0] ctl_idx, pio_idx, pm_idx, sm_idx;

  hbr_first_hit #(.N(NUM_CTL), .IW(IDX_W)) u_ctl_pick (
    .hit(ctl_hit), .any(ctl_any), .idx(ctl_idx));
  hbr_first_hit #(.N(NUM_PIO), .IW(IDX_W)) u_pio_pick (
    .hit(pio_hit), .any(pio_any), .idx(pio_idx));
  hbr_first_hit #(.N(NUM_PM), .IW(IDX_W)) u_pm_pick (
    .hit(pm_hit), .any(pm_any), .idx(pm_idx));
  hbr_first_hit #(.N(NUM_SM), .IW(IDX_W)) u_sm_pick (
    .hit(sm_hit), .any(sm_any), .idx(sm_idx));

  // selected memory-window parameters
  logic [ADDR_W-1:0] pm_sel_bot, pm_sel_iob, pio_sel_bot;
  logic              pm_sel_rel;

  always_comb begin
    pm_sel_bot = '0;
    pm_sel_iob = '0;
    pm_sel_rel = 1'b0;
    for (int i = 0; i < NUM_PM; i++) begin
      if (pm_idx == IDX_W'(i)) begin
        pm_sel_bot = pm_bot[i];
        pm_sel_iob = pm_iob[i];
        pm_sel_rel = pm_rel[i];
      end
    end
    pio_sel_bot = '0;
    for (int i = 0; i < NUM_PIO; i++) begin
      if (pio_idx == IDX_W'(i)) pio_sel_bot = pio_bot[i];
    end
  end

  route_e            nx_route;
  logic [IDX_W-1:0]  nx_idx;
  logic [ADDR_W-1:0] nx_addr;

  always_comb begin
    nx_route = RT_UNDEF;
    nx_idx   = '0;
    nx_addr  = req_addr;
    if (ctl_any) begin
      nx_route = RT_CTL;
      nx_idx   = ctl_idx;
    end else if (pio_any) begin
      nx_route = RT_PIO;
      nx_idx   = pio_idx;
      nx_addr  = req_addr - pio_sel_bot;
    end else if (pm_any) begin
      nx_route = RT_PMEM;
      nx_idx   = pm_idx;
      if (pm_sel_rel && (pm_sel_bot >= FOUR_G))
        nx_addr = req_addr - pm_sel_bot + pm_sel_iob;
    end else if (sm_any) begin
      nx_route = RT_SMEM;
      nx_idx   = sm_idx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_route <= RT_UNDEF;
      rsp_idx   <= '0;
      rsp_addr  <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= req_valid && (nx_route == RT_UNDEF);
      if (req_valid) begin
        rsp_route <= nx_route;
        rsp_idx   <= nx_idx;
        rsp_addr  <= nx_addr;
      end
    end
  end

endmodule

// File: rtl/hbr_addr_router_chk.sv
module hbr_addr_router_chk #(
  parameter int ADDR_W = 48,
  parameter int NUM_PM = 2
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        req_valid,
  input logic [ADDR_W-1:0]           req_addr,
  input logic                        rsp_valid,
  input logic [2:0]                  rsp_route,
  input logic [2:0]                  rsp_idx,
  input logic [ADDR_W-1:0]           rsp_addr,
  input logic                        rsp_err,
  input logic [ADDR_W-1:0]           pio_bot,
  input logic [ADDR_W-1:0]           pio_top,
  input logic [NUM_PM-1:0][ADDR_W-1:0] pm_bot
);

  localparam logic [ADDR_W-1:0] FOUR_G = ADDR_W'(64'h1_0000_0000);

  logic [NUM_PM-1:0] pm_low, pm_low_q;
  logic              rsp_pm_low;

  always_comb begin
    for (int i = 0; i < NUM_PM; i++) pm_low[i] = pm_bot[i] < FOUR_G;
    rsp_pm_low = 1'b0;
    for (int i = 0; i < NUM_PM; i++)
      if (rsp_idx == 3'(i)) rsp_pm_low = pm_low_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst) pm_low_q <= '0;
    else     pm_low_q <= pm_low;
  end

  a_r1_resp_follows: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  a_r1_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);

  a_r8_err_only_undef: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> (rsp_valid && rsp_route == 3'd0));

  a_r8_undef_flags: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_route == 3'd0) |-> rsp_err);

  a_r4_pio_in_range: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_route == 3'd2) |-> (rsp_addr <= $past(pio_top) - $past(pio_bot)));

  a_r7_smem_passthru: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_route == 3'd4) |-> (rsp_addr == $past(req_addr)));

  a_r3_ctl_passthru: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_route == 3'd1) |-> (rsp_addr == $past(req_addr)));

  a_r5_low_window_passthru: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_route == 3'd3 && rsp_pm_low) |-> (rsp_addr == $past(req_addr)));

  a_r2_pm_idx_range: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_route == 3'd3) |-> (32'(rsp_idx) < NUM_PM));

endmodule

bind hbr_addr_router hbr_addr_router_chk #(
  .ADDR_W(ADDR_W), .NUM_PM(NUM_PM)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
  .rsp_valid(rsp_valid), .rsp_route(rsp_route), .rsp_idx(rsp_idx),
  .rsp_addr(rsp_addr), .rsp_err(rsp_err),
  .pio_bot(pio_bot[0]), .pio_top(pio_top[0]), .pm_bot(pm_bot)
);

// File: tb/hbr_addr_router_test.sv
`timescale 1ns/1ps
module hbr_addr_router_test;

  localparam int AW = 48;
  localparam int NC = 2;
  localparam int NP = 2;
  localparam int NS = 4;
  localparam logic [AW-1:0] G4 = 48'h1_0000_0000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [3:0]    cfg_kind = '0;
  logic [2:0]    cfg_idx = '0;
  logic [AW-1:0] cfg_wdata = '0;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic          rsp_valid;
  logic [2:0]    rsp_route;
  logic [2:0]    rsp_idx;
  logic [AW-1:0] rsp_addr;
  logic          rsp_err;

  int nvec  = 0;
  int nfail = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  hbr_addr_router #(.ADDR_W(AW), .NUM_CTL(NC), .NUM_PM(NP), .NUM_SM(NS)) uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
    .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .req_valid(req_valid),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_route(rsp_route),
    .rsp_idx(rsp_idx), .rsp_addr(rsp_addr), .rsp_err(rsp_err));

  // bench-side copy of the configuration
  logic [AW-1:0] c_bot[NC], c_top[NC]; bit c_en[NC];
  logic [AW-1:0] i_bot, i_top;         bit i_en;
  logic [AW-1:0] p_bot[NP], p_top[NP], p_iob[NP]; bit p_en[NP], p_rel[NP];
  logic [AW-1:0] s_bot[NS], s_top[NS]; bit s_en[NS];

  function automatic bit inr(input logic [AW-1:0] a, input logic [AW-1:0] b,
                             input logic [AW-1:0] t, input bit e);
    return e && a >= b && a <= t;
  endfunction

  function automatic void expect_of(input logic [AW-1:0] a, output logic [2:0] r,
                                    output logic [2:0] ix, output logic [AW-1:0] o,
                                    output bit e);
    r = 3'd0; ix = 3'd0; o = a; e = 1'b1;
    for (int k = NS - 1; k >= 0; k--)
      if (inr(a, s_bot[k], s_top[k], s_en[k])) begin r = 3'd4; ix = 3'(k); e = 1'b0; end
    for (int k = NP - 1; k >= 0; k--)
      if (inr(a, p_bot[k], p_top[k], p_en[k])) begin
        r = 3'd3; ix = 3'(k); e = 1'b0;
        o = (p_rel[k] && p_bot[k] >= G4) ? (a - p_bot[k] + p_iob[k]) : a;
      end
    if (inr(a, i_bot, i_top, i_en)) begin r = 3'd2; ix = 3'd0; e = 1'b0; o = a - i_bot; end
    for (int k = NC - 1; k >= 0; k--)
      if (inr(a, c_bot[k], c_top[k], c_en[k])) begin r = 3'd1; ix = 3'(k); e = 1'b0; o = a; end
  endfunction

  function automatic string tag_of(input logic [2:0] r);
    case (r)
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R6";
      3'd4: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic cfg_wr(input logic [3:0] k, input int ix, input logic [AW-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_kind = k; cfg_idx = 3'(ix); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    case (k)
      4'd0:  if (ix < NC) c_bot[ix] = d;
      4'd1:  if (ix < NC) c_top[ix] = d;
      4'd2:  if (ix == 0) i_bot = d;
      4'd3:  if (ix == 0) i_top = d;
      4'd4:  if (ix < NP) p_bot[ix] = d;
      4'd5:  if (ix < NP) p_top[ix] = d;
      4'd6:  if (ix < NP) p_iob[ix] = d;
      4'd7:  if (ix > 0 && ix < NS) s_bot[ix] = {d[AW-1:12], 12'h000};
      4'd8:  if (ix < NS) s_top[ix] = d;
      4'd9:  if (ix < NC) c_en[ix] = d[0];
      4'd10: if (ix == 0) i_en = d[0];
      4'd11: if (ix < NP) begin p_en[ix] = d[0]; p_rel[ix] = d[1]; end
      4'd12: if (ix < NS) s_en[ix] = d[0];
      default: ;
    endcase
  endtask

  task automatic probe(input logic [AW-1:0] a, input string tag);
    logic [2:0] er, ei; logic [AW-1:0] eo; bit ee;
    expect_of(a, er, ei, eo, ee);
    if (tag == "") tag = tag_of(er);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    nvec++;
    if (rsp_valid !== 1'b1 || rsp_route !== er || rsp_idx !== ei ||
        rsp_addr !== eo || rsp_err !== ee) begin
      nfail++;
      $display("FAIL %s addr=%h got v=%b route=%0d idx=%0d out=%h err=%b exp v=1 route=%0d idx=%0d out=%h err=%b",
               tag, a, rsp_valid, rsp_route, rsp_idx, rsp_addr, rsp_err, er, ei, eo, ee);
    end
  endtask

  task automatic idle_check;
    @(negedge clk);
    nvec++;
    if (rsp_valid !== 1'b0 || rsp_err !== 1'b0) begin
      nfail++;
      $display("FAIL R1 idle got v=%b err=%b exp v=0 err=0", rsp_valid, rsp_err);
    end
  endtask

  function automatic logic [AW-1:0] pick_addr();
    int reg_sel = $urandom_range(0, 11);
    int how     = $urandom_range(0, 4);
    logic [AW-1:0] b, t;
    case (reg_sel)
      0, 1:   begin b = c_bot[reg_sel]; t = c_top[reg_sel]; end
      2:      begin b = i_bot; t = i_top; end
      3, 4:   begin b = p_bot[reg_sel-3]; t = p_top[reg_sel-3]; end
      5, 6, 7, 8: begin b = s_bot[reg_sel-5]; t = s_top[reg_sel-5]; end
      9:      return {$urandom(), $urandom()} ;
      default: return AW'({$urandom_range(0, 7), $urandom()});
    endcase
    case (how)
      0: return b;
      1: return t;
      2: return b - 1;
      3: return t + 1;
      default: return b + ((t - b) & AW'({$urandom(), $urandom()}));
    endcase
  endfunction

  initial begin
    for (int k = 0; k < NC; k++) begin c_bot[k] = 0; c_top[k] = 0; c_en[k] = 0; end
    for (int k = 0; k < NP; k++) begin p_bot[k] = 0; p_top[k] = 0; p_iob[k] = 0; p_en[k] = 0; p_rel[k] = 0; end
    for (int k = 0; k < NS; k++) begin s_bot[k] = 0; s_top[k] = 0; s_en[k] = 0; end
    i_bot = 0; i_top = 0; i_en = 0;
    void'($urandom(32'd20240611));

    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10: reset state
    idle_check();
    probe(48'h0, "R10");
    probe(48'h1234_5678, "R10");
    idle_check();

    cfg_wr(4'd8, 0, 48'h0FFF_FFFF);  cfg_wr(4'd12, 0, 1);
    cfg_wr(4'd7, 1, 48'h1000_0123);  cfg_wr(4'd8, 1, 48'h1FFF_FFFF); cfg_wr(4'd12, 1, 1);
    cfg_wr(4'd7, 2, G4);             cfg_wr(4'd8, 2, 48'h3_FFFF_FFFF); cfg_wr(4'd12, 2, 1);
    cfg_wr(4'd0, 0, 48'hFF00_0000);  cfg_wr(4'd1, 0, 48'hFFFF_FFFF); cfg_wr(4'd9, 0, 1);
    cfg_wr(4'd2, 0, 48'hF800_0000);  cfg_wr(4'd3, 0, 48'hF800_FFFF); cfg_wr(4'd10, 0, 1);
    cfg_wr(4'd4, 0, 48'h8000_0000);  cfg_wr(4'd5, 0, 48'hBFFF_FFFF);
    cfg_wr(4'd6, 0, 48'h4000_0000);  cfg_wr(4'd11, 0, 3);
    cfg_wr(4'd4, 1, 48'h10_0000_0000); cfg_wr(4'd5, 1, 48'h10_0FFF_FFFF);
    cfg_wr(4'd6, 1, 48'hC000_0000);  cfg_wr(4'd11, 1, 3);

    // R7: space 0 bottom fixed, page-aligned bottom of space 1
    cfg_wr(4'd7, 0, 48'h5000);
    probe(48'h0, "R7");
    probe(48'h1000_0000, "R7");
    probe(48'h0FFF_FFFF, "R7");
    // R3: inclusive control bounds
    probe(48'hFF00_0000, "R3");
    probe(48'hFFFF_FFFF, "R3");
    probe(48'hFEFF_FFFF, "R8");
    // R4: I/O rebase
    probe(48'hF800_0000, "R4");
    probe(48'hF800_ABCD, "R4");
    probe(48'hF801_0000, "R8");
    // R5: low window ignores relocate
    probe(48'h9234_5678, "R5");
    // R6: high window relocation, then pass-through with bit clear
    probe(48'h10_0000_0000, "R6");
    probe(48'h10_0ABC_DEF0, "R6");
    cfg_wr(4'd11, 1, 1);
    probe(48'h10_0ABC_DEF0, "R6");
    cfg_wr(4'd11, 1, 3);
    // R2: priority control over I/O, memory window over system memory
    cfg_wr(4'd0, 1, 48'hF800_0000); cfg_wr(4'd1, 1, 48'hF800_0FFF); cfg_wr(4'd9, 1, 1);
    probe(48'hF800_0010, "R2");
    cfg_wr(4'd9, 1, 0);
    probe(48'hF800_0010, "R2");
    cfg_wr(4'd7, 3, 48'h8000_0000); cfg_wr(4'd8, 3, 48'h8FFF_FFFF); cfg_wr(4'd12, 3, 1);
    probe(48'h8000_0040, "R2");
    // R9: disabled window
    cfg_wr(4'd10, 0, 0);
    probe(48'hF800_0004, "R9");
    cfg_wr(4'd10, 0, 1);
    // R11: out-of-range index ignored
    cfg_wr(4'd4, 5, 48'h0);
    cfg_wr(4'd11, 5, 3);
    probe(48'h4000_0000, "R11");
    // R8: undefined space
    probe(48'hFFFF_FFFF_FFFF, "R8");

    // random phase
    for (int n = 0; n < 3000; n++) begin
      probe(pick_addr(), "");
      if ((n % 500) == 0) idle_check();
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL R1 watchdog expired got hang exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

endmodule